// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer set up through a single byte-wide control register. The byte holds three fields. A two-bit scale code picks a power of four. A five-bit count gives a multiplier. A top bit chooses how a timeout is reported. The timer counts strobes on `tick_i`, which an outside prescaler delivers once every sixteenth of a second. The timeout therefore lasts multiplier × 4^scale strobes.

Software keeps the watchdog alive by writing the register again or by reading it. Either access reloads the full interval. If the count runs out, a sticky timeout flag is raised. When the steer bit is set, the block then asks for a system reset. It also clears its own control register and tells the neighbouring calendar logic to drop its century-enable bit. When the steer bit is clear, it raises a single interrupt pulse. A control value whose multiplier is zero gives an interval of zero, and that value leaves the timer stopped.

Top module: `steer_wdog`

## Requirements
- R1: The control byte is laid out as scale code S in bits [1:0], multiplier M in bits [6:2] and steer bit in bit 7. A write stores the byte, and `reg_rdata_o` returns the stored byte in the cycle after the write.
- R2: After a write, the timeout occurs on the edge that takes the M×4^S-th `tick_i` strobe. `flag_o` and the selected pulse rise in the cycle after that edge.
- R3: When M is zero, whatever S is (this includes the byte 0x00), the timer stays stopped and never times out.
- R4: A write clears `flag_o` and reloads the count from the new byte's interval. A `tick_i` that arrives in the same cycle as the write is not counted.
- R5: A read (`reg_rd_i`) clears `flag_o` and reloads the count from the interval of the byte already stored.
- R6: `flag_o` is set at timeout and stays set until the next write or read.
- R7: A timeout with the steer bit set gives a one-cycle pulse on `rst_req_o` and on `century_clr_o`, and the stored byte reads back as 0x00 from that cycle onward.
- R8: A timeout with the steer bit clear gives exactly one one-cycle pulse on `irq_o` and leaves the stored byte unchanged.
- R9: After a timeout the counter stops. Further strobes produce no further timeout until the next write or read.
- R10: Synchronous reset clears the stored byte, the flag and all pulses, and stops the counter.
- R11: A write takes priority over a read in the same cycle. A write or read in the cycle of the final strobe restarts the count, and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe every 1/16 s |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_rd_i | input | 1 | Control register read strobe (restarts the count) |
| reg_wdata_i | input | 8 | Control byte to write |
| reg_rdata_o | output | 8 | Stored control byte |
| flag_o | output | 1 | Sticky timeout flag |
| century_clr_o | output | 1 | Pulse telling the calendar logic to clear its century-enable bit |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle timeout interrupt |

## Verification
The bound checker checks on every cycle:
- reset request and interrupt are never high together;
- each pulse lasts exactly one cycle;
- a reset request comes with the century clear and an empty register;
- a rising flag always comes with one of the pulses;
- an access clears the flag;
- a write is stored.

The checker cannot see when a timeout falls: the exact M×4^S strobe count, a read reloading from the stored value, a zero multiplier never expiring, and a restart beating the final strobe. Those appear only when the bench's behavioural model, stepped once per clock, is compared against the ports across the scenarios.

// File: rtl/steer_wdog_pkg.sv
package steer_wdog_pkg;
    localparam int RES_W   = 2;
    localparam int MULT_W  = 5;
    localparam int REG_W   = 1 + MULT_W + RES_W;
    localparam int MAX_RES = (1 << RES_W) - 1;
    localparam int CNT_W   = MULT_W + 2 * MAX_RES;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    function automatic logic [CNT_W-1:0] interval_of(input wd_cfg_t c);
        return CNT_W'(c.mult) << {c.res, 1'b0};
    endfunction
endpackage

// File: rtl/steer_wdog_reload.sv
module steer_wdog_reload
    import steer_wdog_pkg::*;
(
    input  logic             wr,
    input  logic             rd,
    input  wd_cfg_t          wdata,
    input  wd_cfg_t          cur,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    wd_cfg_t src;

    always_comb begin
        src      = wr ? wdata : cur;
        load     = wr | rd;
        load_val = interval_of(src);
    end
endmodule

// File: rtl/steer_wdog_count.sv
module steer_wdog_count
    import steer_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign expire = run_q && tick && !load && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= |load_val;
        end else if (expire) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/steer_wdog_action.sv
module steer_wdog_action
    import steer_wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  logic    rd,
    input  wd_cfg_t wdata,
    input  logic    expire,
    output wd_cfg_t cfg,
    output logic    flag,
    output logic    rst_req,
    output logic    irq,
    output logic    cen_clr
);
    wd_cfg_t cfg_q;

    assign cfg = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            flag    <= 1'b0;
            rst_req <= 1'b0;
            irq     <= 1'b0;
            cen_clr <= 1'b0;
        end else begin
            rst_req <= expire && cfg_q.steer;
            cen_clr <= expire && cfg_q.steer;
            irq     <= expire && !cfg_q.steer;
            if (wr) begin
                cfg_q <= wdata;
            end else if (expire && cfg_q.steer) begin
                cfg_q <= '0;
            end
            if (wr || rd) begin
                flag <= 1'b0;
            end else if (expire) begin
                flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/steer_wdog.sv
module steer_wdog
    import steer_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             flag_o,
    output logic             century_clr_o,
    output logic             rst_req_o,
    output logic             irq_o
);
    wd_cfg_t          cfg;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expire;

    steer_wdog_reload u_reload (
        .wr       (reg_wr_i),
        .rd       (reg_rd_i),
        .wdata    (wd_cfg_t'(reg_wdata_i)),
        .cur      (cfg),
        .load     (load),
        .load_val (load_val)
    );

    steer_wdog_count u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .tick     (tick_i),
        .expire   (expire)
    );

    steer_wdog_action u_action (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr_i),
        .rd      (reg_rd_i),
        .wdata   (wd_cfg_t'(reg_wdata_i)),
        .expire  (expire),
        .cfg     (cfg),
        .flag    (flag_o),
        .rst_req (rst_req_o),
        .irq     (irq_o),
        .cen_clr (century_clr_o)
    );

    assign reg_rdata_o = REG_W'(cfg);
endmodule

// File: rtl/steer_wdog_chk.sv
module steer_wdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr_i,
    input logic       reg_rd_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       flag_o,
    input logic       century_clr_o,
    input logic       rst_req_o,
    input logic       irq_o
);
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(rst_req_o && irq_o));

    p_rst_single_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    p_rst_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> (century_clr_o && reg_rdata_o == 8'h00));

    p_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> (rst_req_o || irq_o));

    p_wr_clears_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> !flag_o);

    p_rd_clears_r5: assert property (@(posedge clk) disable iff (rst)
        reg_rd_i |=> !flag_o);

    p_wr_stores_r1: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> reg_rdata_o == $past(reg_wdata_i));
endmodule

bind steer_wdog steer_wdog_chk u_chk (.*);

// File: tb/sim_steer_wdog.sv
module sim_steer_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       flag_o, century_clr_o, rst_req_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    steer_wdog u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .flag_o(flag_o), .century_clr_o(century_clr_o),
        .rst_req_o(rst_req_o), .irq_o(irq_o)
    );

    // behavioural reference model
    int       m_cnt = 0;
    bit       m_run = 0;
    bit [7:0] m_cfg = 0;
    bit       m_flag = 0, m_rst = 0, m_irq = 0, m_cc = 0;
    bit       m_valid = 0;

    function automatic int span(input bit [7:0] v);
        int m = int'(v[6:2]);
        int s = int'(v[1:0]);
        return m * (4 ** s);
    endfunction

    always @(posedge clk) begin
        m_rst = 0; m_irq = 0; m_cc = 0;
        m_valid = 1;
        if (rst) begin
            m_cnt = 0; m_run = 0; m_cfg = 0; m_flag = 0;
        end else if (reg_wr_i) begin
            m_cfg  = reg_wdata_i;
            m_flag = 0;
            m_cnt  = span(reg_wdata_i);
            m_run  = (m_cnt != 0);
        end else if (reg_rd_i) begin
            m_flag = 0;
            m_cnt  = span(m_cfg);
            m_run  = (m_cnt != 0);
        end else if (tick_i && m_run) begin
            if (m_cnt == 1) begin
                m_flag = 1;
                m_run  = 0;
                if (m_cfg[7]) begin
                    m_cfg = 0; m_rst = 1; m_cc = 1;
                end else begin
                    m_irq = 1;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid) begin
            chk("R1 model rdata", reg_rdata_o, m_cfg);
            chk("R6 model flag", {7'd0, flag_o}, {7'd0, m_flag});
            chk("R7 model rst_req", {7'd0, rst_req_o}, {7'd0, m_rst});
            chk("R7 model century_clr", {7'd0, century_clr_o}, {7'd0, m_cc});
            chk("R8 model irq", {7'd0, irq_o}, {7'd0, m_irq});
        end
    end

    task automatic drive(input bit w, input bit r, input bit [7:0] d, input bit t);
        reg_wr_i = w; reg_rd_i = r; reg_wdata_i = d; tick_i = t;
        @(negedge clk);
        reg_wr_i = 0; reg_rd_i = 0; tick_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 8'h00, 1);
            drive(0, 0, 8'h00, 0);
        end
    endtask

    task automatic main_seq();
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 reset rdata", reg_rdata_o, 8'h00);
        chk("R10 reset flag", {7'd0, flag_o}, 8'h00);
        rst = 0;
        ticks(3);
        chk("R10 stopped after reset", {7'd0, flag_o}, 8'h00);

        // R2/R8: 0x05 -> M=1, S=1 -> 4 strobes, interrupt steering
        drive(1, 0, 8'h05, 1);
        chk("R1 stored", reg_rdata_o, 8'h05);
        ticks(3);
        chk("R2 not yet", {7'd0, flag_o}, 8'h00);
        drive(0, 0, 8'h00, 1);
        chk("R2 flag at 4th strobe", {7'd0, flag_o}, 8'h01);
        chk("R8 irq pulse", {7'd0, irq_o}, 8'h01);
        chk("R8 byte kept", reg_rdata_o, 8'h05);
        drive(0, 0, 8'h00, 0);
        chk("R8 irq one cycle", {7'd0, irq_o}, 8'h00);
        ticks(10);
        chk("R6 flag sticky", {7'd0, flag_o}, 8'h01);

        // R5: read restarts, 0x09 -> 8 strobes
        drive(1, 0, 8'h09, 0);
        chk("R4 write clears flag", {7'd0, flag_o}, 8'h00);
        ticks(5);
        drive(0, 1, 8'h00, 0);
        ticks(7);
        chk("R5 read restarted", {7'd0, flag_o}, 8'h00);
        drive(0, 0, 8'h00, 1);
        chk("R5 expiry after reload", {7'd0, flag_o}, 8'h01);
        drive(0, 1, 8'h00, 0);
        chk("R5 read clears flag", {7'd0, flag_o}, 8'h00);

        // R7: 0x84 -> 1 strobe, reset steering
        drive(1, 0, 8'h84, 0);
        drive(0, 0, 8'h00, 1);
        chk("R7 rst_req", {7'd0, rst_req_o}, 8'h01);
        chk("R7 century clear", {7'd0, century_clr_o}, 8'h01);
        chk("R7 byte cleared", reg_rdata_o, 8'h00);
        drive(0, 0, 8'h00, 0);
        chk("R7 rst_req one cycle", {7'd0, rst_req_o}, 8'h00);
        ticks(4);
        chk("R9 no second timeout", {7'd0, irq_o | rst_req_o}, 8'h00);

        // R3: zero multiplier
        drive(1, 0, 8'h03, 0);
        ticks(300);
        chk("R3 zero M stopped", {7'd0, flag_o}, 8'h00);
        drive(1, 0, 8'h00, 0);
        ticks(20);
        chk("R3 zero byte stopped", {7'd0, flag_o}, 8'h00);

        // R2 large: 0x07 -> 64 strobes
        drive(1, 0, 8'h07, 0);
        ticks(63);
        chk("R2 64 not yet", {7'd0, flag_o}, 8'h00);
        drive(0, 0, 8'h00, 1);
        chk("R2 64 expiry", {7'd0, flag_o}, 8'h01);

        // R11 write beats read
        drive(1, 1, 8'h0D, 0);
        chk("R11 write wins", reg_rdata_o, 8'h0D);
        ticks(11);
        chk("R11 12-strobe not yet", {7'd0, flag_o}, 8'h00);
        drive(0, 0, 8'h00, 1);
        chk("R11 12-strobe expiry", {7'd0, flag_o}, 8'h01);

        // R11 read on final strobe prevents expiry
        drive(1, 0, 8'h04, 0);
        drive(0, 1, 8'h00, 1);
        chk("R11 restart beats expiry", {7'd0, flag_o | irq_o}, 8'h00);
        drive(0, 0, 8'h00, 1);
        chk("R11 expiry after restart", {7'd0, flag_o}, 8'h01);

        // R4 tick with write not counted
        drive(1, 0, 8'h08, 1);
        ticks(1);
        chk("R4 strobe with write ignored", {7'd0, flag_o}, 8'h00);
        ticks(1);
        chk("R4 expiry at 2nd strobe", {7'd0, flag_o}, 8'h01);

        // R10 reset mid-run
        drive(1, 0, 8'h05, 0);
        ticks(2);
        rst = 1;
        drive(0, 0, 8'h00, 0);
        rst = 0;
        chk("R10 reset clears byte", reg_rdata_o, 8'h00);
        ticks(10);
        chk("R10 counter stopped", {7'd0, flag_o}, 8'h00);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (MAX_CYCLES) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule